// File: doc/BRIEF.md
# Pipelined floating-point adder and subtractor

This block adds or subtracts two binary floating-point words in the standard interchange format. Its default is half precision (5 exponent bits, 10 fraction bits). The exponent and fraction widths are parameters, so the same code also covers single precision. Each operation carries a 3-bit rounding-mode code and a small tag. The tag leaves the block unchanged, next to the result it belongs to.

Operands enter through a valid/ready handshake. They pass through two registered stages:

- The first stage handles the special operands. It orders the magnitudes, aligns the smaller significand with guard, round and sticky bits, and adds or subtracts.
- The second stage normalises, rounds, resolves overflow and packs the word.

Subnormal operands and subnormal results are handled exactly, with no flushing. The result is bit-exact for every mode, including two round-to-odd variants and a fixed NaN payload rule.

Top module: `fp_addsub`

## Requirements
- R1: While reset is asserted, and after it is released with no input, `out_valid_o` is 0 and `in_ready_o` is 1.
- R2: Mode code 0 gives the correctly rounded value of a+b, or of a−b when `sub_i` is 1, with ties to even. Mode code 7 behaves exactly as code 0. Subnormal operands and results are exact, with no flushing.
- R3: Mode code 1 rounds toward zero, code 2 rounds toward +infinity and code 3 rounds toward −infinity. Each is bit-exact.
- R4: Mode code 4 rounds to nearest with ties away from zero.
- R5: Codes 5 and 6 are round-to-odd. An inexact result takes the truncated magnitude with its least significant bit set to 1. An exact result is returned unchanged.
- R6: An exact zero result of opposite-signed operands is −0 under codes 3 and 6, and +0 under every other code. Two zeros of the same effective sign give that sign.
- R7: If operand a is a NaN, the result is a with the quiet bit set. The quiet bit is the top fraction bit, bit 9 at half precision.
- R8: If a is not a NaN and b is a NaN, the result is b's original bits with the quiet bit set. The subtract flag does not change b's sign in this case.
- R9: Infinities of opposite effective sign give the canonical NaN. The canonical NaN has sign 0, an all-ones exponent and only the quiet bit set: 0x7E00 at half precision.
- R10: An infinite operand with a finite one returns that infinity with its effective sign. On overflow, codes 0, 4 and 7 give infinity. Codes 1, 5 and 6 give the largest finite value. Code 2 gives infinity only for a positive result, and code 3 only for a negative one.
- R11: Every accepted input gives exactly one output transfer, in order, with its tag on `id_o`. While `out_ready_i` is low, a pending output keeps its valid, result and tag stable.
- R12: With `out_ready_i` held low, the block accepts two inputs and then drops `in_ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands are offered |
| in_ready_o | output | 1 | Block can take operands this cycle |
| a_i | input | 1+EXP_W+MAN_W | Operand a |
| b_i | input | 1+EXP_W+MAN_W | Operand b |
| sub_i | input | 1 | 1 computes a−b, 0 computes a+b |
| rm_i | input | 3 | Rounding-mode code |
| id_i | input | ID_W | Tag passed through with the operation |
| out_valid_o | output | 1 | Result is offered |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 1+EXP_W+MAN_W | Rounded sum or difference |
| id_o | output | ID_W | Tag of the result |

## Verification
The assertions check the following on every cycle:

- A stalled stage holds its data.
- No output transfer happens without an input in flight.
- A full pipeline under backpressure refuses input.
- Aligned subtraction never goes negative.
- Every NaN leaving the rounder is quiet.
- Inexact round-to-odd results end in a 1.

Bit-exact rounding in each mode, the sign of exact zeros, NaN payload priority, overflow per mode and tag ordering can only be shown by the bench's scenarios. The bench compares the block against an exact integer model of the arithmetic. It uses directed corner cases: ties, subnormal boundaries, cancellation, infinities, NaNs and overflow. These are followed by random operand mixes under random backpressure.

// File: rtl/fpadd_pkg.sv
`timescale 1ns/1ps
package fpadd_pkg;
  localparam logic [2:0] RM_RNE  = 3'd0;
  localparam logic [2:0] RM_RTZ  = 3'd1;
  localparam logic [2:0] RM_RTP  = 3'd2;
  localparam logic [2:0] RM_RTN  = 3'd3;
  localparam logic [2:0] RM_RNA  = 3'd4;
  localparam logic [2:0] RM_ODDP = 3'd5;
  localparam logic [2:0] RM_ODDN = 3'd6;

  function automatic logic is_odd_mode(input logic [2:0] rm);
    return (rm == RM_ODDP) || (rm == RM_ODDN);
  endfunction
endpackage

// File: rtl/fpadd_stage_reg.sv
`timescale 1ns/1ps
module fpadd_stage_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o
);
  logic          valid_q;
  logic [DW-1:0] data_q;

  assign in_ready_o  = !valid_q || out_ready_i;
  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (in_valid_i && in_ready_o) begin
      valid_q <= 1'b1;
      data_q  <= in_data_i;
    end else if (out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !out_ready_i |=> valid_q && $stable(data_q));
endmodule

// File: rtl/fpadd_align.sv
`timescale 1ns/1ps
module fpadd_align
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  parameter int ID_W  = 4,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int EXT_W = SIG_W + 3,
  localparam int SUM_W = EXT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic             sub_i,
  input  logic [2:0]       rm_i,
  input  logic [ID_W-1:0]  id_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [ID_W-1:0]  id_o,
  output logic [2:0]       rm_o,
  output logic             special_o,
  output logic [W-1:0]     special_val_o,
  output logic             zero_sign_o,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SUM_W-1:0] sum_o
);
  localparam int PW = ID_W + 3 + 1 + W + 1 + 1 + EXP_W + SUM_W;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [W-1:0] QBIT = W'(1) << (MAN_W - 1);
  localparam logic [W-1:0] CNAN = {1'b0, EMAX, 1'b1, {(MAN_W-1){1'b0}}};

  logic sa, sb;
  logic [EXP_W-1:0] ea, eb;
  logic [MAN_W-1:0] fa, fb;
  logic a_nan, b_nan, a_inf, b_inf;

  assign sa = a_i[W-1];
  assign sb = b_i[W-1] ^ sub_i;
  assign ea = a_i[W-2:MAN_W];
  assign eb = b_i[W-2:MAN_W];
  assign fa = a_i[MAN_W-1:0];
  assign fb = b_i[MAN_W-1:0];
  assign a_nan = (ea == EMAX) && (fa != '0);
  assign b_nan = (eb == EMAX) && (fb != '0);
  assign a_inf = (ea == EMAX) && (fa == '0);
  assign b_inf = (eb == EMAX) && (fb == '0);

  // NaN payload priority: a, then b, then canonical
  logic         special;
  logic [W-1:0] special_val;
  always_comb begin
    special     = 1'b1;
    special_val = CNAN;
    if (a_nan)                      special_val = a_i | QBIT;
    else if (b_nan)                 special_val = b_i | QBIT;
    else if (a_inf && b_inf && (sa != sb)) special_val = CNAN;
    else if (a_inf)                 special_val = a_i;
    else if (b_inf)                 special_val = {sb, b_i[W-2:0]};
    else                            special = 1'b0;
  end

  logic             swap, s_big;
  logic [EXP_W-1:0] ea_eff, eb_eff, e_big, e_small, d;
  logic [SIG_W-1:0] sig_a, sig_b, sig_big, sig_small;
  logic [EXT_W-1:0] big_ext, small_ext, al, al_f;
  logic             sticky, eff_sub, zero_sign;
  logic [SUM_W-1:0] sum;

  assign swap    = b_i[W-2:0] > a_i[W-2:0];
  assign ea_eff  = (ea == '0) ? EXP_W'(1) : ea;
  assign eb_eff  = (eb == '0) ? EXP_W'(1) : eb;
  assign sig_a   = {ea != '0, fa};
  assign sig_b   = {eb != '0, fb};
  assign e_big   = swap ? eb_eff : ea_eff;
  assign e_small = swap ? ea_eff : eb_eff;
  assign sig_big   = swap ? sig_b : sig_a;
  assign sig_small = swap ? sig_a : sig_b;
  assign s_big   = swap ? sb : sa;
  assign d       = e_big - e_small;
  assign big_ext   = {sig_big, 3'b000};
  assign small_ext = {sig_small, 3'b000};

  always_comb begin
    if (d >= EXP_W'(EXT_W)) begin
      al     = '0;
      sticky = |sig_small;
    end else begin
      al     = small_ext >> d;
      sticky = |(small_ext & ~({EXT_W{1'b1}} << d));
    end
  end

  assign al_f    = {al[EXT_W-1:1], al[0] | sticky};
  assign eff_sub = sa ^ sb;
  assign sum     = eff_sub ? ({1'b0, big_ext} - {1'b0, al_f})
                           : ({1'b0, big_ext} + {1'b0, al_f});
  // sign of an exact zero result
  assign zero_sign = (sa == sb) ? sa : ((rm_i == RM_RTN) || (rm_i == RM_ODDN));

  logic [PW-1:0] pay_d, pay_q;
  assign pay_d = {id_i, rm_i, special, special_val, zero_sign, s_big, e_big, sum};

  fpadd_stage_reg #(.DW(PW)) i_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  (pay_d),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o (pay_q)
  );

  assign {id_o, rm_o, special_o, special_val_o, zero_sign_o, sign_o, exp_o, sum_o} = pay_q;

  assert_align_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !special && eff_sub |-> ({1'b0, big_ext} >= {1'b0, al_f}));
endmodule

// File: rtl/fpadd_round.sv
`timescale 1ns/1ps
module fpadd_round
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  parameter int ID_W  = 4,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int EXT_W = SIG_W + 3,
  localparam int SUM_W = EXT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [ID_W-1:0]  id_i,
  input  logic [2:0]       rm_i,
  input  logic             special_i,
  input  logic [W-1:0]     special_val_i,
  input  logic             zero_sign_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SUM_W-1:0] sum_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [W-1:0]     result_o,
  output logic [ID_W-1:0]  id_o
);
  localparam int XW = EXP_W + 2;
  localparam int BW = EXP_W + MAN_W + 1;
  localparam logic [EXP_W-1:0] EMAX = '1;
  localparam logic [EXP_W-1:0] EBIG = EMAX - 1'b1;

  function automatic logic [XW-1:0] count_lz(input logic [EXT_W-1:0] v);
    logic [XW-1:0] n;
    logic hit;
    n = '0;
    hit = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!hit && !v[i]) n = n + 1'b1;
      else hit = 1'b1;
    end
    return n;
  endfunction

  logic [XW-1:0]    lz, exp_x, exp_m1, sh, n_exp;
  logic [EXT_W-1:0] n_sig;
  logic [SIG_W-1:0] q;
  logic             g, st, inexact, inc, ovf, to_inf;
  logic [BW-1:0]    base;
  logic [W-1:0]     res;

  assign lz     = count_lz(sum_i[EXT_W-1:0]);
  assign exp_x  = XW'(exp_i);
  assign exp_m1 = exp_x - 1'b1;
  // left shift stops at the subnormal boundary
  assign sh     = (lz < exp_m1) ? lz : exp_m1;

  always_comb begin
    if (sum_i[SUM_W-1]) begin
      n_sig = {sum_i[SUM_W-1:2], sum_i[1] | sum_i[0]};
      n_exp = exp_x + 1'b1;
    end else begin
      n_sig = sum_i[EXT_W-1:0] << sh;
      n_exp = exp_x - sh;
    end
  end

  assign q       = n_sig[EXT_W-1:3];
  assign g       = n_sig[2];
  assign st      = |n_sig[1:0];
  assign inexact = g | st;

  always_comb begin
    case (rm_i)
      RM_RTZ, RM_ODDP, RM_ODDN: begin inc = 1'b0;              to_inf = 1'b0;    end
      RM_RTP:                   begin inc = inexact && !sign_i; to_inf = !sign_i; end
      RM_RTN:                   begin inc = inexact && sign_i;  to_inf = sign_i;  end
      RM_RNA:                   begin inc = g;                  to_inf = 1'b1;    end
      default:                  begin inc = g && (st || q[0]);  to_inf = 1'b1;    end
    endcase
  end

  // hidden bit of q carries into the exponent field
  always_comb begin
    base = (BW'(n_exp - 1'b1) << MAN_W) + BW'(q) + BW'(inc);
    if (is_odd_mode(rm_i)) base[0] = base[0] | inexact;
  end

  assign ovf = base >= (BW'(EMAX) << MAN_W);

  always_comb begin
    if (special_i)             res = special_val_i;
    else if (sum_i == '0)      res = {zero_sign_i, {(W-1){1'b0}}};
    else if (ovf && to_inf)    res = {sign_i, EMAX, {MAN_W{1'b0}}};
    else if (ovf)              res = {sign_i, EBIG, {MAN_W{1'b1}}};
    else                       res = {sign_i, base[W-2:0]};
  end

  fpadd_stage_reg #(.DW(ID_W + W)) i_stage (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .in_data_i  ({id_i, res}),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_data_o ({id_o, result_o})
  );

  assert_odd_lsb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !special_i && is_odd_mode(rm_i) && inexact && (sum_i != '0) |-> res[0]);

  assert_nan_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (res[W-2:MAN_W] == EMAX) && (res[MAN_W-1:0] != '0) |-> res[MAN_W-1]);
endmodule

// File: rtl/fp_addsub.sv
`timescale 1ns/1ps
module fp_addsub #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  parameter int ID_W  = 4,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SUM_W = MAN_W + 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            sub_i,
  input  logic [2:0]      rm_i,
  input  logic [ID_W-1:0] id_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [W-1:0]    result_o,
  output logic [ID_W-1:0] id_o
);
  logic             s1_valid, s1_ready, s1_special, s1_zero_sign, s1_sign;
  logic [ID_W-1:0]  s1_id;
  logic [2:0]       s1_rm;
  logic [W-1:0]     s1_special_val;
  logic [EXP_W-1:0] s1_exp;
  logic [SUM_W-1:0] s1_sum;

  fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .ID_W(ID_W)) i_align (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_ready_o   (in_ready_o),
    .a_i          (a_i),
    .b_i          (b_i),
    .sub_i        (sub_i),
    .rm_i         (rm_i),
    .id_i         (id_i),
    .out_valid_o  (s1_valid),
    .out_ready_i  (s1_ready),
    .id_o         (s1_id),
    .rm_o         (s1_rm),
    .special_o    (s1_special),
    .special_val_o(s1_special_val),
    .zero_sign_o  (s1_zero_sign),
    .sign_o       (s1_sign),
    .exp_o        (s1_exp),
    .sum_o        (s1_sum)
  );

  fpadd_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .ID_W(ID_W)) i_round (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (s1_valid),
    .in_ready_o   (s1_ready),
    .id_i         (s1_id),
    .rm_i         (s1_rm),
    .special_i    (s1_special),
    .special_val_i(s1_special_val),
    .zero_sign_i  (s1_zero_sign),
    .sign_i       (s1_sign),
    .exp_i        (s1_exp),
    .sum_i        (s1_sum),
    .out_valid_o  (out_valid_o),
    .out_ready_i  (out_ready_i),
    .result_o     (result_o),
    .id_o         (id_o)
  );

  // in-flight count, used only by the checks below
  logic [1:0] inflight_q;
  logic       in_fire, out_fire;
  assign in_fire  = in_valid_i && in_ready_o;
  assign out_fire = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   inflight_q <= '0;
    else if (in_fire && !out_fire) inflight_q <= inflight_q + 1'b1;
    else if (out_fire && !in_fire) inflight_q <= inflight_q - 1'b1;
  end

  assert_one_out_per_in_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_fire |-> inflight_q != 2'd0);

  assert_stall_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inflight_q == 2'd2) && !out_ready_i |-> !in_ready_o);
endmodule

// File: tb/test_fp_addsub.sv
`timescale 1ns/1ps
module test_fp_addsub;
  localparam int ID_W = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_ni, in_valid_i, in_ready_o, sub_i, out_valid_o, out_ready_i;
  logic [15:0] a_i, b_i, result_o;
  logic [2:0] rm_i;
  logic [ID_W-1:0] id_i, id_o;

  fp_addsub i_fp_addsub (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .a_i(a_i), .b_i(b_i), .sub_i(sub_i), .rm_i(rm_i), .id_i(id_i),
    .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .result_o(result_o), .id_o(id_o)
  );

  int n_checks = 0, n_fail = 0, n_sent = 0, n_recv = 0;
  int bp_mode = 0;
  logic [ID_W-1:0] next_id = '0;
  logic [19:0] sb_q[$];
  string tag_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  // exact integer model, units of the smallest subnormal
  function automatic logic [15:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                          input logic sub, input logic [2:0] rm,
                                          output string tag);
    logic sa, sb, neg, inexact, inc, odd, to_inf;
    logic [4:0] ea, eb;
    logic [9:0] fa, fb;
    longint va, vb, s, m, q, rem, half, bits;
    int l, sh;
    sa = a[15]; sb = b[15] ^ sub;
    ea = a[14:10]; eb = b[14:10]; fa = a[9:0]; fb = b[9:0];
    if (ea == 5'h1F && fa != 0) begin tag = "R7"; return a | 16'h0200; end
    if (eb == 5'h1F && fb != 0) begin tag = "R8"; return b | 16'h0200; end
    if (ea == 5'h1F && eb == 5'h1F && sa != sb) begin tag = "R9"; return 16'h7E00; end
    if (ea == 5'h1F) begin tag = "R10"; return a; end
    if (eb == 5'h1F) begin tag = "R10"; return {sb, b[14:0]}; end
    va = (ea == 0) ? longint'(fa) : (longint'({1'b1, fa}) << (ea - 1));
    vb = (eb == 0) ? longint'(fb) : (longint'({1'b1, fb}) << (eb - 1));
    s = (sa ? -va : va) + (sb ? -vb : vb);
    if (s == 0) begin
      tag = "R6";
      return {(sa == sb) ? sa : (rm == 3'd3 || rm == 3'd6), 15'h0};
    end
    neg = s < 0;
    m = neg ? -s : s;
    l = 0;
    while ((m >> l) != 0) l++;
    sh = (l > 11) ? l - 11 : 0;
    q = m >> sh;
    rem = m - (q << sh);
    half = (sh > 0) ? (longint'(1) << (sh - 1)) : 0;
    inexact = rem != 0;
    odd = 1'b0;
    case (rm)
      3'd1: begin inc = 0; to_inf = 0; end
      3'd2: begin inc = inexact && !neg; to_inf = !neg; end
      3'd3: begin inc = inexact && neg; to_inf = neg; end
      3'd4: begin inc = (sh > 0) && (rem >= half); to_inf = 1; end
      3'd5, 3'd6: begin inc = 0; odd = 1; to_inf = 0; end
      default: begin inc = (sh > 0) && ((rem > half) || (rem == half && q[0])); to_inf = 1; end
    endcase
    if (odd && inexact) q = q | 1;
    bits = (longint'(sh) << 10) + q + longint'(inc);
    if (bits >= 'h7C00) begin
      tag = "R10";
      return to_inf ? {neg, 15'h7C00} : {neg, 15'h7BFF};
    end
    case (rm)
      3'd1, 3'd2, 3'd3: tag = "R3";
      3'd4: tag = "R4";
      3'd5, 3'd6: tag = "R5";
      default: tag = "R2";
    endcase
    return {neg, bits[14:0]};
  endfunction

  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic sub,
                      input logic [2:0] rm);
    string t;
    logic [15:0] e;
    e = ref_add(a, b, sub, rm, t);
    a_i = a; b_i = b; sub_i = sub; rm_i = rm; id_i = next_id; in_valid_i = 1'b1;
    forever begin
      #1;
      if (in_ready_o) break;
      @(negedge clk);
    end
    sb_q.push_back({next_id, e});
    tag_q.push_back(t);
    next_id = next_id + 1'b1;
    n_sent++;
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  function automatic logic [15:0] rand_op();
    logic [15:0] r;
    r = 16'($urandom);
    case ($urandom % 10)
      0: return {r[15], 5'h00, r[9:0]};
      1: return {r[15], 5'h1F, 10'h0};
      2: return {r[15], 5'h1F, r[9:0] | 10'h001};
      3: return {r[15], 15'h0};
      4: return {r[15], 5'h1E, r[9:0]};
      default: return r;
    endcase
  endfunction

  // consumer backpressure
  initial begin
    out_ready_i = 1'b1;
    forever begin
      @(negedge clk);
      case (bp_mode)
        0: out_ready_i = 1'b1;
        1: out_ready_i = ($urandom % 4) != 0;
        default: out_ready_i = 1'b0;
      endcase
    end
  end

  // scoreboard monitor
  initial begin
    logic [19:0] it;
    string t;
    forever begin
      @(negedge clk);
      #1;
      if (rst_ni && out_valid_o && out_ready_i) begin
        n_recv++;
        if (sb_q.size() == 0) begin
          check(1'b0, "R11", "unexpected output", 32'(result_o), 32'h0);
        end else begin
          it = sb_q.pop_front();
          t = tag_q.pop_front();
          check(result_o == it[15:0], t, "result", 32'(result_o), 32'(it[15:0]));
          check(id_o == it[19:16], "R11", "tag order", 32'(id_o), 32'(it[19:16]));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
    $finish;
  end

  initial begin
    int acc;
    logic [15:0] ra, rb;
    rst_ni = 1'b0; in_valid_i = 1'b0; a_i = '0; b_i = '0; sub_i = 1'b0; rm_i = '0; id_i = '0;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid_o == 1'b0, "R1", "valid in reset", 32'(out_valid_o), 0);
    check(in_ready_o == 1'b1, "R1", "ready in reset", 32'(in_ready_o), 1);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(out_valid_o == 1'b0, "R1", "valid after reset", 32'(out_valid_o), 0);
    check(in_ready_o == 1'b1, "R1", "ready after reset", 32'(in_ready_o), 1);
    @(negedge clk);

    // directed corners: R2 R3 R4 R5 tie and subnormal cases
    for (int m = 0; m < 8; m++) begin
      send(16'h3C00, 16'h1000, 1'b0, 3'(m));
      send(16'hBC00, 16'h9000, 1'b0, 3'(m));
      send(16'h3C00, 16'h1000, 1'b1, 3'(m));
      send(16'h3C00, 16'h0E00, 1'b0, 3'(m));
      send(16'h3C00, 16'h3C00, 1'b0, 3'(m));
      send(16'h03FF, 16'h0001, 1'b0, 3'(m));
      send(16'h0400, 16'h0001, 1'b1, 3'(m));
      send(16'h0001, 16'h8001, 1'b0, 3'(m));
      // R6 zero signs
      send(16'h3C00, 16'h3C00, 1'b1, 3'(m));
      send(16'h0000, 16'h8000, 1'b0, 3'(m));
      send(16'h8000, 16'h0000, 1'b1, 3'(m));
      // R10 overflow and infinity
      send(16'h7BFF, 16'h7BFF, 1'b0, 3'(m));
      send(16'hFBFF, 16'h7BFF, 1'b1, 3'(m));
      send(16'h3C00, 16'h7C00, 1'b1, 3'(m));
      // R7 R8 R9 NaN rules
      send(16'h7C01, 16'h3C00, 1'b0, 3'(m));
      send(16'h3C00, 16'hFC05, 1'b1, 3'(m));
      send(16'hFD00, 16'h7C03, 1'b0, 3'(m));
      send(16'h7C00, 16'h7C00, 1'b1, 3'(m));
      send(16'h7C00, 16'hFC00, 1'b0, 3'(m));
    end

    // random mix under backpressure
    bp_mode = 1;
    for (int i = 0; i < 3000; i++) begin
      ra = rand_op();
      rb = (($urandom % 4) == 0) ? (ra ^ 16'(($urandom % 8))) : rand_op();
      send(ra, rb, 1'(($urandom % 2)), 3'($urandom % 8));
    end
    bp_mode = 0;
    for (int i = 0; i < 400 && sb_q.size() != 0; i++) @(negedge clk);

    // R12 stall: two accepted, then ready drops; R11 output held
    bp_mode = 2;
    @(negedge clk);
    acc = 0;
    a_i = 16'h3C00; b_i = 16'h4000; sub_i = 1'b0; rm_i = 3'd0; in_valid_i = 1'b1;
    for (int c = 0; c < 6; c++) begin
      id_i = next_id;
      #1;
      if (in_ready_o) begin
        sb_q.push_back({next_id, 16'h4200});
        tag_q.push_back("R2");
        next_id = next_id + 1'b1;
        n_sent++;
        acc++;
      end
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    #1;
    check(acc == 2, "R12", "accepted under stall", 32'(acc), 2);
    check(in_ready_o == 1'b0, "R12", "ready under stall", 32'(in_ready_o), 0);
    check(out_valid_o == 1'b1, "R11", "valid held", 32'(out_valid_o), 1);
    check(result_o == 16'h4200, "R11", "result held", 32'(result_o), 32'h4200);
    bp_mode = 0;
    for (int i = 0; i < 50 && sb_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "R11", "pending items", 32'(sb_q.size()), 0);
    check(n_recv == n_sent, "R11", "outputs vs inputs", 32'(n_recv), 32'(n_sent));
    report();
    $finish;
  end
endmodule